// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a countdown watchdog that software reaches through a small 32-bit register window. Software sets a start count in a reload register and turns counting on through a control word. The running count is refreshed only when software writes one fixed key word to the restart register. A missed refresh lets the count run out.

When the count runs out, control bits choose what follows. The block can send a one-cycle system reset request together with a scope code, a one-cycle external trigger pulse, and a sticky flag that selects the secondary boot image. An optional early-warning interrupt fires when the remaining count reaches a threshold packed into the upper control bits. The count steps on a 1 MHz tick divided down from the system clock, or on every clock when the slow tick is not selected. A status register records what happened, and a write-one clear register resets it.

Top module: `wdt_timer`

## Requirements
- R1: Byte offsets: 0x00 returns the live count, 0x04 the reload value, 0x0C the control word and 0x10 the status in bits 2:0. Any other offset, including 0x08 and 0x14, reads zero. Writes to 0x00 and 0x10 change nothing.
- R2: A write of exactly 32'h0000_4755 to 0x08 loads the count from the reload value, leaves the expired state and clears status bit 2. A write of any other value to 0x08 changes nothing.
- R3: Control bit 0 enables counting. Each tick lowers the count by one. A tick that finds the count at zero is the expiry: the count stays at zero and no further expiry happens until a restart or a disable. With bit 0 low the count holds.
- R4: With control bit 4 set, one tick occurs every TICK_DIV clocks from a free-running divider. With bit 4 clear, every clock is a tick.
- R5: On expiry with control bit 1 set, `rst_req` is high for exactly the one cycle after the expiry edge. During that cycle `rst_scope` carries control bits 6:5 (0 = SoC, 1 = full chip, 2 = CPU only). At all other times `rst_scope` is zero.
- R6: On expiry with control bit 3 set, `ext_pulse` is high for exactly the one cycle after the expiry edge.
- R7: With control bit 2 set, a tick that moves the count to the threshold in control bits 31:10 sets status bit 2. `wd_irq` follows status bit 2 as a level.
- R8: Expiry sets status bit 0. If control bit 7 is also set, expiry sets status bit 1. `alt_boot` follows status bit 1 and stays set until it is cleared.
- R9: A write to 0x14 with bit 0 set clears status bits 2:0. A write there with bit 0 clear has no effect. If a status event occurs in the same cycle as the clear, the event wins.
- R10: After reset the reload value and the count are RELOAD_INIT (all ones by default), the control word and the status are zero, and all outputs are low.
- R11: The full 32-bit range counts down from 32'hFFFF_FFFF without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wd_irq | output | 1 | Pre-timeout interrupt level |
| rst_req | output | 1 | One-cycle system reset request |
| rst_scope | output | 2 | Reset scope code, valid with rst_req |
| ext_pulse | output | 1 | One-cycle external trigger |
| alt_boot | output | 1 | Sticky secondary-boot select |

## Verification
The assertions assume that reset is held high from time zero and for several cycles, so every past value they sample is a reset value. They also assume that bus writes are single-cycle strobes with stable address and data, and that only the restart key write ever raises the count. The stimulus drives all inputs a fixed delay after the rising edge and holds reset for five clocks. Restart writes carry the exact key or deliberate near misses. Reload values and thresholds are kept small, so expiry, the threshold hit and clears all occur many times in a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DW = 32;

    localparam logic [7:0] OFF_COUNT = 8'h00;
    localparam logic [7:0] OFF_LOAD  = 8'h04;
    localparam logic [7:0] OFF_KICK  = 8'h08;
    localparam logic [7:0] OFF_CTRL  = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h10;
    localparam logic [7:0] OFF_CLR   = 8'h14;

    localparam logic [DW-1:0] KICK_KEY = 32'h0000_4755;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'd0,
        SCOPE_CHIP = 2'd1,
        SCOPE_CPU  = 2'd2,
        SCOPE_RSVD = 2'd3
    } scope_e;

    // control word, MSB first; bit positions are software visible
    typedef struct packed {
        logic [21:0] pre_thr;
        logic [1:0]  spare;
        logic        arm_alt;
        scope_e      scope;
        logic        slow_tick;
        logic        ext_en;
        logic        irq_en;
        logic        rst_en;
        logic        run;
    } ctrl_t;

    typedef struct packed {
        logic pre_hit;
        logic alt_boot;
        logic expired;
    } stat_t;

    typedef struct packed {
        logic kick;
        logic clear;
        logic ld_wr;
        logic cfg_wr;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_cmd(input logic wr,
                                            input logic [7:0] a,
                                            input logic [DW-1:0] d);
        bus_cmd_t c;
        c.kick   = wr && (a == OFF_KICK) && (d == KICK_KEY);
        c.clear  = wr && (a == OFF_CLR) && d[0];
        c.ld_wr  = wr && (a == OFF_LOAD);
        c.cfg_wr = wr && (a == OFF_CTRL);
        return c;
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter logic [DW-1:0] INIT = 32'hFFFF_FFFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          kick,
    input  logic [DW-1:0] reload,
    input  logic          irq_en,
    input  logic [21:0]   thr,
    output logic [DW-1:0] cnt,
    output logic          exp_evt,
    output logic          pre_evt
);
    logic [DW-1:0] cnt_q;
    logic          done_q;
    logic          step;
    logic [DW-1:0] dec;

    assign step    = run && tick && !done_q && !kick;
    assign dec     = cnt_q - 1'b1;
    assign exp_evt = step && (cnt_q == '0);
    assign pre_evt = step && irq_en && (cnt_q != '0) && (dec == {10'b0, thr});
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= INIT;
            done_q <= 1'b0;
        end else if (kick) begin
            cnt_q  <= reload;
            done_q <= 1'b0;
        end else if (!run) begin
            done_q <= 1'b0;
        end else if (step) begin
            if (cnt_q == '0) done_q <= 1'b1;
            else             cnt_q  <= dec;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter logic [DW-1:0] INIT = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     cnt,
    input  logic              exp_evt,
    input  logic              pre_evt,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     reload,
    output logic              kick,
    output logic              clear,
    output stat_t             stat,
    output logic [DW-1:0]     rdata
);
    logic [7:0] a8;
    bus_cmd_t   cmd;
    ctrl_t      ctrl_q;
    logic [DW-1:0] load_q;
    stat_t      stat_q;
    stat_t      stat_d;

    assign a8  = 8'(addr);
    assign cmd = decode_cmd(wr, a8, wdata);

    always_comb begin
        stat_d = stat_q;
        if (cmd.clear) stat_d = '0;
        if (cmd.kick)  stat_d.pre_hit = 1'b0;
        if (exp_evt) begin
            stat_d.expired = 1'b1;
            if (ctrl_q.arm_alt) stat_d.alt_boot = 1'b1;
        end
        if (pre_evt) stat_d.pre_hit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= INIT;
            stat_q <= '0;
        end else begin
            if (cmd.cfg_wr) ctrl_q <= ctrl_t'(wdata);
            if (cmd.ld_wr)  load_q <= wdata;
            stat_q <= stat_d;
        end
    end

    always_comb begin
        case (a8)
            OFF_COUNT: rdata = cnt;
            OFF_LOAD:  rdata = load_q;
            OFF_CTRL:  rdata = DW'(ctrl_q);
            OFF_STAT:  rdata = {{(DW-3){1'b0}}, stat_q};
            default:   rdata = '0;
        endcase
    end

    assign ctrl   = ctrl_q;
    assign reload = load_q;
    assign kick   = cmd.kick;
    assign clear  = cmd.clear;
    assign stat   = stat_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int TICK_DIV = 250,
    parameter int ADDR_W = 5,
    parameter logic [31:0] RELOAD_INIT = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_irq,
    output logic              rst_req,
    output logic [1:0]        rst_scope,
    output logic              ext_pulse,
    output logic              alt_boot
);
    ctrl_t         ctrl_w;
    stat_t         stat_w;
    logic [DW-1:0] reload_w;
    logic [DW-1:0] cnt_w;
    logic          kick_w;
    logic          clear_w;
    logic          exp_evt;
    logic          pre_evt;
    logic          slow_tick;
    logic          tick;
    logic          rq_q;
    logic [1:0]    sc_q;
    logic          ext_q;

    wdt_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(slow_tick)
    );

    assign tick = ctrl_w.slow_tick ? slow_tick : 1'b1;

    wdt_regs #(.ADDR_W(ADDR_W), .INIT(RELOAD_INIT)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cnt    (cnt_w),
        .exp_evt(exp_evt),
        .pre_evt(pre_evt),
        .ctrl   (ctrl_w),
        .reload (reload_w),
        .kick   (kick_w),
        .clear  (clear_w),
        .stat   (stat_w),
        .rdata  (bus_rdata)
    );

    wdt_count #(.INIT(RELOAD_INIT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (ctrl_w.run),
        .kick   (kick_w),
        .reload (reload_w),
        .irq_en (ctrl_w.irq_en),
        .thr    (ctrl_w.pre_thr),
        .cnt    (cnt_w),
        .exp_evt(exp_evt),
        .pre_evt(pre_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_q  <= 1'b0;
            sc_q  <= 2'b00;
            ext_q <= 1'b0;
        end else begin
            rq_q  <= exp_evt && ctrl_w.rst_en;
            sc_q  <= (exp_evt && ctrl_w.rst_en) ? ctrl_w.scope : SCOPE_SOC;
            ext_q <= exp_evt && ctrl_w.ext_en;
        end
    end

    assign rst_req   = rq_q;
    assign rst_scope = sc_q;
    assign ext_pulse = ext_q;
    assign wd_irq    = stat_w.pre_hit;
    assign alt_boot  = stat_w.alt_boot;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        rst_req,
    input logic [1:0]  rst_scope,
    input logic        ext_pulse,
    input logic        wd_irq,
    input logic        alt_boot,
    input logic        kick,
    input logic        clear,
    input logic        exp_evt,
    input logic [31:0] cnt
);
    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R5
    scope_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_scope != 2'b00) |-> rst_req);

    // R6
    ext_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ext_pulse |=> !ext_pulse);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_irq) |-> $past(kick || clear));

    // R8
    boot_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_boot) |-> $past(exp_evt));

    // R3
    no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt > $past(cnt)) |-> $past(kick));
endmodule

bind wdt_timer wdt_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rst_req  (rst_req),
    .rst_scope(rst_scope),
    .ext_pulse(ext_pulse),
    .wd_irq   (wd_irq),
    .alt_boot (alt_boot),
    .kick     (kick_w),
    .clear    (clear_w),
    .exp_evt  (exp_evt),
    .cnt      (cnt_w)
);

// File: tb/sim_wdt_timer.sv
`timescale 1ns/1ps
module sim_wdt_timer;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_irq, rst_req, ext_pulse, alt_boot;
    logic [1:0]  rst_scope;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wdt_timer #(.TICK_DIV(DIV), .ADDR_W(5)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_irq(wd_irq),
        .rst_req(rst_req), .rst_scope(rst_scope), .ext_pulse(ext_pulse),
        .alt_boot(alt_boot)
    );

    // reference state built from the requirements
    int          m_pre;
    logic [31:0] m_cnt, m_rld, m_cfg;
    logic        m_exp, m_rq, m_ext;
    logic [1:0]  m_sc;
    logic [2:0]  m_sts;

    always @(posedge clk) begin
        logic tk, kk, cl, st, ev, pv;
        logic [2:0] ns;
        if (rst) begin
            m_pre <= 0; m_cnt <= 32'hFFFF_FFFF; m_rld <= 32'hFFFF_FFFF;
            m_cfg <= '0; m_exp <= 1'b0; m_rq <= 1'b0; m_ext <= 1'b0;
            m_sc <= 2'b00; m_sts <= 3'b000;
        end else begin
            tk = m_cfg[4] ? (m_pre == DIV - 1) : 1'b1;
            kk = bus_wr && bus_addr == 5'h08 && bus_wdata == 32'h4755;
            cl = bus_wr && bus_addr == 5'h14 && bus_wdata[0];
            st = m_cfg[0] && tk && !m_exp && !kk;
            ev = st && m_cnt == 0;
            pv = st && m_cfg[2] && m_cnt != 0 && (m_cnt - 1) == {10'b0, m_cfg[31:10]};
            m_pre <= (m_pre == DIV - 1) ? 0 : m_pre + 1;
            if (kk) begin m_cnt <= m_rld; m_exp <= 1'b0; end
            else if (!m_cfg[0]) m_exp <= 1'b0;
            else if (st) begin
                if (m_cnt == 0) m_exp <= 1'b1;
                else m_cnt <= m_cnt - 1;
            end
            ns = m_sts;
            if (cl) ns = 3'b000;
            if (kk) ns[2] = 1'b0;
            if (ev) begin ns[0] = 1'b1; if (m_cfg[7]) ns[1] = 1'b1; end
            if (pv) ns[2] = 1'b1;
            m_sts <= ns;
            m_rq  <= ev && m_cfg[1];
            m_sc  <= (ev && m_cfg[1]) ? m_cfg[6:5] : 2'b00;
            m_ext <= ev && m_cfg[3];
            if (bus_wr && bus_addr == 5'h04) m_rld <= bus_wdata;
            if (bus_wr && bus_addr == 5'h0C) m_cfg <= bus_wdata;
        end
    end

    function automatic logic [31:0] mread(input logic [4:0] a);
        case (a)
            5'h00:   return m_cnt;
            5'h04:   return m_rld;
            5'h0C:   return m_cfg;
            5'h10:   return {29'b0, m_sts};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1 read data", bus_rdata, mread(bus_addr));
        chk("R7 wd_irq", 32'(wd_irq), 32'(m_sts[2]));
        chk("R5 rst_req", 32'(rst_req), 32'(m_rq));
        chk("R5 rst_scope", 32'(rst_scope), 32'(m_sc));
        chk("R6 ext_pulse", 32'(ext_pulse), 32'(m_ext));
        chk("R8 alt_boot", 32'(alt_boot), 32'(m_sts[1]));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] v, c0, c1;
        int pulses;
        void'($urandom(32'd2024));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        // R10 reset state
        rd(5'h00, v); chk("R10 count after reset", v, 32'hFFFF_FFFF);
        rd(5'h04, v); chk("R10 reload after reset", v, 32'hFFFF_FFFF);
        rd(5'h0C, v); chk("R10 control after reset", v, 32'h0);
        rd(5'h10, v); chk("R10 status after reset", v, 32'h0);
        chk("R10 outputs after reset", {rst_req, ext_pulse, wd_irq, alt_boot, rst_scope}, 0);
        // R11 top of range counts down
        wr(5'h0C, 32'h1);
        step(); step(); step();
        rd(5'h00, v); chk("R11 count from all ones", v, 32'hFFFF_FFFC);
        // R1 / R2 map and key
        wr(5'h0C, 32'h0);
        wr(5'h04, 32'd7);
        rd(5'h00, c0);
        wr(5'h08, 32'h4756);
        rd(5'h00, v); chk("R2 wrong key ignored", v, c0);
        wr(5'h08, 32'h0001_4755);
        rd(5'h00, v); chk("R2 upper bits break key", v, c0);
        wr(5'h00, 32'h123);
        rd(5'h00, v); chk("R1 count write ignored", v, c0);
        wr(5'h10, 32'h7);
        rd(5'h10, v); chk("R1 status write ignored", v, 32'h0);
        wr(5'h08, 32'h4755);
        rd(5'h00, v); chk("R2 key loads count", v, 32'd7);
        rd(5'h04, v); chk("R1 reload readback", v, 32'd7);
        rd(5'h08, v); chk("R1 restart reads zero", v, 32'h0);
        // R4 tick rate
        wr(5'h04, 32'd1000); wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h11);
        rd(5'h00, c0);
        repeat (20) step();
        rd(5'h00, c1); chk("R4 slow tick count", c0 - c1, 32'd5);
        wr(5'h0C, 32'h01);
        rd(5'h00, c0);
        repeat (20) step();
        rd(5'h00, c1); chk("R4 fast tick count", c0 - c1, 32'd20);
        // R3 R5 R6 R8 expiry
        wr(5'h0C, 32'h0); wr(5'h04, 32'd3); wr(5'h08, 32'h4755);
        wr(5'h0C, 32'hCB);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (rst_req) begin
                pulses++;
                chk("R5 scope with pulse", 32'(rst_scope), 32'd2);
                chk("R6 ext with pulse", 32'(ext_pulse), 32'd1);
            end
        end
        chk("R5 single reset pulse", pulses, 1);
        rd(5'h00, v); chk("R3 stops at zero", v, 32'h0);
        chk("R8 alt_boot sticky", 32'(alt_boot), 32'd1);
        rd(5'h10, v); chk("R8 status bits", v, 32'h3);
        // R9 clear
        wr(5'h14, 32'h0);
        rd(5'h10, v); chk("R9 clear bit0 low ignored", v, 32'h3);
        wr(5'h14, 32'h1);
        rd(5'h10, v); chk("R9 clear status", v, 32'h0);
        chk("R9 alt_boot cleared", 32'(alt_boot), 32'd0);
        // R7 pre-timeout
        wr(5'h0C, 32'h0); wr(5'h04, 32'd20); wr(5'h08, 32'h4755);
        wr(5'h0C, (32'd5 << 10) | 32'h5);
        repeat (30) step();
        chk("R7 irq raised", 32'(wd_irq), 32'd1);
        wr(5'h08, 32'h4755);
        chk("R2 key clears irq", 32'(wd_irq), 32'd0);
        wr(5'h0C, 32'h0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = $urandom % 9;
            case (op)
                0: wr(5'h04, $urandom % 40);
                1: wr(5'h08, 32'h4755);
                2: wr(5'h08, 32'h4755 ^ (32'h1 << ($urandom % 32)));
                3: wr(5'h0C, {22'($urandom % 30), 10'($urandom)});
                4: wr(5'h14, 32'($urandom % 2));
                5: wr((($urandom % 2) == 0) ? 5'h00 : 5'h10, $urandom);
                default: begin
                    bus_addr = 5'(4 * ($urandom % 6));
                    step();
                end
            endcase
        end
        finish_up();
    end
endmodule